// File: doc/BRIEF.md
# Zero-group opcode decoder

This block classifies 16-bit instruction words whose bits 15:9 are all zero. Bits 8:6 select a sub-group, and the word then maps to exactly one of ten operation selects or one of four trap requests. The operations are halt, wait, return-from-trap, bus reset, jump, return-from-subroutine, set-priority, condition-code set/clear, swap-bytes and the always-taken branch. The traps are breakpoint, I/O trap, reserved instruction and illegal halt. A kernel-mode flag decides whether a halt word halts the machine or raises the illegal-halt trap.

The decoder also passes on the raw fields that later stages need: the register number, the 6-bit operand specifier, the 8-bit branch offset, and the condition-code set flag with its mask. It does not calculate addresses, touch the stack, take branches or execute anything. All outputs are registered and appear one clock after the instruction word is presented. Words with any of bits 15:9 set produce no select and no trap.

Top module: `zg_decode`

## Requirements
- R1: While rst_n is low, every output is zero.
- R2: Each output is due one clock edge after instr_i and kernel_i are sampled. A word with bits 8:6 = 1 sets op_sel_o[4] (jump), and a word with bits 8:6 = 3 sets op_sel_o[8] (swap bytes).
- R3: A word with bits 8:6 in the range 4 to 7 (bit 8 set) sets op_sel_o[9] (branch), whatever the value of bits 7:6.
- R4: In sub-group 0 (bits 8:6 = 0), the following words set these selects: word 1 sets op_sel_o[1] (wait), words 2 and 6 both set op_sel_o[2] (return-from-trap), and word 5 sets op_sel_o[3] (bus reset).
- R5: In sub-group 0, word 3 sets trap_o[0] (breakpoint) and word 4 sets trap_o[1] (I/O trap).
- R6: Word 0 sets op_sel_o[0] (halt) when kernel_i is 1. When kernel_i is 0 it sets trap_o[3] (illegal halt) instead, and op_sel_o[0] stays low.
- R7: With bits 8:6 = 2, the value of bits 5:3 selects the operation. A value of 0 sets op_sel_o[5] (return-from-subroutine), 3 sets op_sel_o[6] (set-priority), and 4 to 7 sets op_sel_o[7] (condition-code set/clear).
- R8: trap_o[2] (reserved instruction) is raised in two cases: sub-group 0 words 7 to 63, and bits 8:6 = 2 with bits 5:3 equal to 1 or 2.
- R9: A word with any of bits 15:9 set leaves op_sel_o and trap_o all zero.
- R10: At most one bit of {op_sel_o, trap_o} is ever high, and exactly one is high for every word whose bits 15:9 are zero.
- R11: The field outputs come straight from the word one clock later, for every word: reg_o is bits 2:0, spec_o is bits 5:0, boff_o is bits 7:0, cc_set_o is bit 4 and cc_mask_o is bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| kernel_i | input | 1 | 1 when the processor is in kernel mode |
| op_sel_o | output | 10 | One-hot operation select |
| trap_o | output | 4 | Trap requests: breakpoint, I/O, reserved, illegal halt |
| reg_o | output | 3 | Register field (bits 2:0) |
| spec_o | output | 6 | Operand specifier (bits 5:0) |
| boff_o | output | 8 | Branch word offset (bits 7:0) |
| cc_set_o | output | 1 | Condition-code set (1) or clear (0) |
| cc_mask_o | output | 4 | Condition-code mask: N, Z, V, C |

## Verification
Every output of this decoder is due exactly one clock after its word is sampled. The bench applies each word on a falling edge. The rising edge that follows registers the result, and the bench compares the outputs against its prediction for that word at the next falling edge, just before it applies the next word. The reference model keeps one expected record per cycle. It sweeps all 512 low-group words under both kernel settings, then a set of words with high bits set, and includes a check made during reset.

// File: rtl/zg_pkg.sv
package zg_pkg;
    localparam int IW      = 16;
    localparam int OP_N    = 10;
    localparam int TRAP_N  = 4;
    localparam int SPEC_W  = 6;
    localparam int REG_W   = 3;
    localparam int BOFF_W  = 8;
    localparam int HI_LSB  = 9;

    localparam int OP_HALT = 0;
    localparam int OP_WAIT = 1;
    localparam int OP_RTT  = 2;
    localparam int OP_RST  = 3;
    localparam int OP_JMP  = 4;
    localparam int OP_RTS  = 5;
    localparam int OP_SPL  = 6;
    localparam int OP_CC   = 7;
    localparam int OP_SWAB = 8;
    localparam int OP_BR   = 9;

    localparam int TR_BPT  = 0;
    localparam int TR_IOT  = 1;
    localparam int TR_RSV  = 2;
    localparam int TR_HLT  = 3;

    typedef struct packed {
        logic [OP_N-1:0]   op;
        logic [TRAP_N-1:0] trap;
        logic [REG_W-1:0]  rn;
        logic [SPEC_W-1:0] spec;
        logic [BOFF_W-1:0] boff;
        logic              ccset;
        logic [3:0]        ccmask;
    } dec_t;
endpackage

// File: rtl/zg_misc_dec.sv
module zg_misc_dec
    import zg_pkg::*;
(
    input  logic [SPEC_W-1:0] low_i,
    input  logic              kernel_i,
    output logic [OP_N-1:0]   op_o,
    output logic [TRAP_N-1:0] trap_o
);
    always_comb begin
        op_o   = '0;
        trap_o = '0;
        if (low_i[5:3] != 3'd0) begin
            trap_o[TR_RSV] = 1'b1;
        end else begin
            case (low_i[2:0])
                3'd0: begin
                    if (kernel_i) op_o[OP_HALT] = 1'b1;
                    else          trap_o[TR_HLT] = 1'b1;
                end
                3'd1:       op_o[OP_WAIT] = 1'b1;
                3'd2, 3'd6: op_o[OP_RTT]  = 1'b1;
                3'd3:       trap_o[TR_BPT] = 1'b1;
                3'd4:       trap_o[TR_IOT] = 1'b1;
                3'd5:       op_o[OP_RST]  = 1'b1;
                default:    trap_o[TR_RSV] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/zg_ctl_dec.sv
module zg_ctl_dec
    import zg_pkg::*;
(
    input  logic [2:0]        mid_i,
    output logic [OP_N-1:0]   op_o,
    output logic [TRAP_N-1:0] trap_o
);
    always_comb begin
        op_o   = '0;
        trap_o = '0;
        if (mid_i[2]) begin
            op_o[OP_CC] = 1'b1;
        end else begin
            case (mid_i[1:0])
                2'd0:    op_o[OP_RTS] = 1'b1;
                2'd3:    op_o[OP_SPL] = 1'b1;
                default: trap_o[TR_RSV] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/zg_decode.sv
module zg_decode
    import zg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     instr_i,
    input  logic              kernel_i,
    output logic [OP_N-1:0]   op_sel_o,
    output logic [TRAP_N-1:0] trap_o,
    output logic [REG_W-1:0]  reg_o,
    output logic [SPEC_W-1:0] spec_o,
    output logic [BOFF_W-1:0] boff_o,
    output logic              cc_set_o,
    output logic [3:0]        cc_mask_o
);
    logic [OP_N-1:0]   misc_op, ctl_op;
    logic [TRAP_N-1:0] misc_trap, ctl_trap;
    dec_t dec_d, dec_q;

    zg_misc_dec u_misc (
        .low_i    (instr_i[SPEC_W-1:0]),
        .kernel_i (kernel_i),
        .op_o     (misc_op),
        .trap_o   (misc_trap)
    );

    zg_ctl_dec u_ctl (
        .mid_i  (instr_i[5:3]),
        .op_o   (ctl_op),
        .trap_o (ctl_trap)
    );

    always_comb begin
        dec_d        = '0;
        dec_d.rn     = instr_i[REG_W-1:0];
        dec_d.spec   = instr_i[SPEC_W-1:0];
        dec_d.boff   = instr_i[BOFF_W-1:0];
        dec_d.ccset  = instr_i[4];
        dec_d.ccmask = instr_i[3:0];
        if (instr_i[IW-1:HI_LSB] == '0) begin
            case (instr_i[8:6])
                3'd0: begin
                    dec_d.op   = misc_op;
                    dec_d.trap = misc_trap;
                end
                3'd1: dec_d.op[OP_JMP] = 1'b1;
                3'd2: begin
                    dec_d.op   = ctl_op;
                    dec_d.trap = ctl_trap;
                end
                3'd3:    dec_d.op[OP_SWAB] = 1'b1;
                default: dec_d.op[OP_BR]   = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign op_sel_o  = dec_q.op;
    assign trap_o    = dec_q.trap;
    assign reg_o     = dec_q.rn;
    assign spec_o    = dec_q.spec;
    assign boff_o    = dec_q.boff;
    assign cc_set_o  = dec_q.ccset;
    assign cc_mask_o = dec_q.ccmask;
endmodule

// File: rtl/zg_decode_chk.sv
module zg_decode_chk
    import zg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [IW-1:0]     instr_i,
    input logic              kernel_i,
    input logic [OP_N-1:0]   op_sel_o,
    input logic [TRAP_N-1:0] trap_o,
    input logic [REG_W-1:0]  reg_o,
    input logic [BOFF_W-1:0] boff_o
);
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_sel_o, trap_o})); // R10

    AST_USER_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i == '0 && !kernel_i) |=> (trap_o[TR_HLT] && !op_sel_o[OP_HALT])); // R6

    AST_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[IW-1:HI_LSB] == '0 && instr_i[8]) |=>
        (op_sel_o[OP_BR] && boff_o == $past(instr_i[BOFF_W-1:0]))); // R3

    AST_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[IW-1:HI_LSB] != '0) |=> (op_sel_o == '0 && trap_o == '0)); // R9

    AST_RSVD_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[IW-1:6] == 10'd2 && (instr_i[5:3] == 3'd1 || instr_i[5:3] == 3'd2))
        |=> trap_o[TR_RSV]); // R8

    AST_REG_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (reg_o == $past(instr_i[REG_W-1:0]))); // R11
endmodule

bind zg_decode zg_decode_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr_i  (instr_i),
    .kernel_i (kernel_i),
    .op_sel_o (op_sel_o),
    .trap_o   (trap_o),
    .reg_o    (reg_o),
    .boff_o   (boff_o)
);

// File: tb/test_zg_decode.sv
module test_zg_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = 16'h0;
    logic        kernel_i = 1'b0;
    logic [9:0]  op_sel_o;
    logic [3:0]  trap_o;
    logic [2:0]  reg_o;
    logic [5:0]  spec_o;
    logic [7:0]  boff_o;
    logic        cc_set_o;
    logic [3:0]  cc_mask_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    zg_decode i_zg_decode (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .kernel_i(kernel_i),
        .op_sel_o(op_sel_o), .trap_o(trap_o), .reg_o(reg_o), .spec_o(spec_o),
        .boff_o(boff_o), .cc_set_o(cc_set_o), .cc_mask_o(cc_mask_o)
    );

    // Behavioural model: returns {op, trap} and the requirement tag for a word.
    task automatic model(input int w, input bit k, output logic [13:0] v, output string tag);
        int grp, mid;
        v = '0;
        grp = (w >> 6) & 7;
        mid = (w >> 3) & 7;
        if (w >= 512) begin
            tag = "R9";
        end else if (w == 0) begin
            tag = "R6";
            if (k) v[4] = 1'b1; else v[3] = 1'b1;
        end else if (w == 1) begin tag = "R4"; v[4+1] = 1'b1;
        end else if (w == 2 || w == 6) begin tag = "R4"; v[4+2] = 1'b1;
        end else if (w == 5) begin tag = "R4"; v[4+3] = 1'b1;
        end else if (w == 3) begin tag = "R5"; v[0] = 1'b1;
        end else if (w == 4) begin tag = "R5"; v[1] = 1'b1;
        end else if (w < 64) begin tag = "R8"; v[2] = 1'b1;
        end else if (grp == 1) begin tag = "R2"; v[4+4] = 1'b1;
        end else if (grp == 3) begin tag = "R2"; v[4+8] = 1'b1;
        end else if (grp >= 4) begin tag = "R3"; v[4+9] = 1'b1;
        end else if (mid == 0) begin tag = "R7"; v[4+5] = 1'b1;
        end else if (mid == 3) begin tag = "R7"; v[4+6] = 1'b1;
        end else if (mid >= 4) begin tag = "R7"; v[4+7] = 1'b1;
        end else begin tag = "R8"; v[2] = 1'b1;
        end
    endtask

    task automatic compare(input int w, input bit k);
        logic [13:0] v;
        string tag;
        model(w, k, v, tag);
        checks++;
        if ({op_sel_o, trap_o} != v) begin
            errors++;
            $display("FAIL %s word=%0o k=%0d got=%b exp=%b", tag, w, k, {op_sel_o, trap_o}, v);
        end
        if (w < 512) begin
            checks++;
            if ($countones({op_sel_o, trap_o}) != 1) begin
                errors++;
                $display("FAIL R10 word=%0o got=%b exp=one-hot", w, {op_sel_o, trap_o});
            end
        end
        checks++;
        if ({reg_o, spec_o, boff_o, cc_set_o, cc_mask_o} !=
            {w[2:0], w[5:0], w[7:0], w[4], w[3:0]}) begin
            errors++;
            $display("FAIL R11 word=%0o got=%h exp=%h", w,
                {reg_o, spec_o, boff_o, cc_set_o, cc_mask_o},
                {w[2:0], w[5:0], w[7:0], w[4], w[3:0]});
        end
    endtask

    // Drive on falling edge; result registered on next rising edge; check on following falling edge.
    task automatic apply(input int w, input bit k);
        instr_i  = w[15:0];
        kernel_i = k;
        @(negedge clk);
        compare(w, k);
    endtask

    initial begin
        @(negedge clk);
        instr_i = 16'o000100;
        @(negedge clk);
        checks++;   // R1
        if ({op_sel_o, trap_o, reg_o, spec_o, boff_o, cc_set_o, cc_mask_o} != '0) begin
            errors++;
            $display("FAIL R1 got=%h exp=0",
                {op_sel_o, trap_o, reg_o, spec_o, boff_o, cc_set_o, cc_mask_o});
        end
        rst_n = 1'b1;
        for (int k = 0; k < 2; k++)
            for (int w = 0; w < 512; w++)
                apply(w, k[0]);
        for (int j = 0; j < 16; j++)
            apply(512 + j * 4093, j[0]);   // R9
        apply(16'o177777, 1'b1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule